// File: doc/BRIEF.md
# Parallel ATA Programmed I/O Register Access Engine

This block is the host side of programmed I/O on a parallel ATA channel. A local bus master presents one register access at a time. Each access carries a register-block select, a 3-bit register index and, for writes, a 16-bit value. The engine then runs a full device cycle. It asserts the matching active-low chip select and the register address, waits out a programmable setup time and pulses the active-low read or write strobe. It keeps that strobe asserted while the device signals it is not ready, and afterwards holds address and select for a programmable hold time.

Every phase length comes from clock-count inputs, so one engine serves any bus speed. Read data is taken from the shared 16-bit bus at the clock edge on which the read strobe is released. On writes the host drives the bus from setup through hold, so the value is steady across the release of the write strobe. The device ready input is synchronized through two flops and is consulted only after the minimum strobe width has passed. A timeout limit bounds how long a not-ready device can stretch a cycle. When it expires, the cycle completes with an error flag.

Top module: `ata_pio_engine`

## Requirements
- R1: With `req_ctl`=0 the access asserts only `ata_cs1_n` low; with `req_ctl`=1 it asserts only `ata_cs3_n` low. Both selects are never low together, and both are high while idle.
- R2: `ata_da` equals the accepted `req_addr` in every cycle in which a chip select is low.
- R3: A chip select and the address are active for max(`cfg_setup`,1) clocks before the strobe goes low. They stay active for max(`cfg_hold`,1) clocks after it returns high.
- R4: A read (`req_write`=0) pulses only `ata_rd_n`, and a write pulses only `ata_wr_n`. With ready high, the strobe is low for exactly W=max(`cfg_strobe`,1) clocks.
- R5: Suppose `ata_ready` is low before the strobe starts and rises during strobe clock k. The strobe is then low for max(W, k+2) clocks, provided this does not exceed W+`cfg_timeout`.
- R6: If ready stays low, the strobe ends after W+`cfg_timeout` clocks and `done_err` is 1 together with `done`. Ready arriving in time gives `done_err`=0.
- R7: On a read, `rdata` holds the bus value present in the last strobe clock, which is the value at strobe release, not at strobe start. It is valid when `done` is 1.
- R8: On a write, the bus carries `req_wdata` in every strobe clock.
- R9: `req_ack` is high in the same cycle as `req_valid` while the engine is idle. A request raised while a cycle is in progress gets no acknowledge and is not run.
- R10: `done` is a single-clock pulse in the first clock after the hold phase, when both chip selects are already high.
- R11: After reset, both selects and both strobes are high, and `done`, `done_err` and `req_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_ack | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_ctl | input | 1 | 0 = command block, 1 = control block |
| req_addr | input | 3 | Register index inside the block |
| req_wdata | input | 16 | Write value |
| cfg_setup | input | 8 | Address setup clocks |
| cfg_strobe | input | 8 | Minimum strobe clocks |
| cfg_hold | input | 8 | Address hold clocks |
| cfg_timeout | input | 12 | Extra clocks allowed while not ready |
| done | output | 1 | Access complete pulse |
| done_err | output | 1 | Access ended by timeout (valid with done) |
| rdata | output | 16 | Read value (valid with done) |
| ata_cs1_n | output | 1 | Command block select, active low |
| ata_cs3_n | output | 1 | Control block select, active low |
| ata_da | output | 3 | Device register address |
| ata_dd | inout | 16 | Device data bus |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_ready | input | 1 | Device ready, low inserts wait states |

## Verification
A phase counter loaded with the wrong value or decremented at the wrong time shows as a setup, strobe or hold phase off by one clock. That error is visible within the same device cycle. A wrong ready path, such as a missing synchronizer stage or ready sampled before the minimum width, changes the measured strobe length of the stretched cycles by a clock or more. A capture taken at the wrong edge returns the stale value that the device model presents at strobe start. A mishandled busy state shows up immediately as an acknowledge to a request raised in mid-cycle.

// File: rtl/ata_pio_engine.sv
module ata_pio_engine #(
  parameter int DW = 16,
  parameter int AW = 3,
  parameter int TW = 8,
  parameter int OW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ack,
  input  logic          req_write,
  input  logic          req_ctl,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [TW-1:0] cfg_setup,
  input  logic [TW-1:0] cfg_strobe,
  input  logic [TW-1:0] cfg_hold,
  input  logic [OW-1:0] cfg_timeout,
  output logic          done,
  output logic          done_err,
  output logic [DW-1:0] rdata,
  output logic          ata_cs1_n,
  output logic          ata_cs3_n,
  output logic [AW-1:0] ata_da,
  inout  wire  [DW-1:0] ata_dd,
  output logic          ata_rd_n,
  output logic          ata_wr_n,
  input  logic          ata_ready
);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STROBE, S_HOLD} st_t;

  st_t           st;
  logic [TW-1:0] cnt;
  logic [OW-1:0] wcnt;
  logic          wr_q, ctl_q, err_q, rs1, rs2;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;

  wire min_done = cnt <= TW'(1);
  wire tmo      = wcnt == cfg_timeout;
  wire active   = st != S_IDLE;
  wire dd_oe    = active && wr_q;

  assign req_ack   = (st == S_IDLE) && req_valid;
  assign ata_cs1_n = !(active && !ctl_q);
  assign ata_cs3_n = !(active && ctl_q);
  assign ata_da    = active ? addr_q : '0;
  assign ata_rd_n  = !(st == S_STROBE && !wr_q);
  assign ata_wr_n  = !(st == S_STROBE && wr_q);
  assign ata_dd    = dd_oe ? wd_q : {DW{1'bz}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; wcnt <= '0;
      wr_q <= 1'b0; ctl_q <= 1'b0; err_q <= 1'b0;
      addr_q <= '0; wd_q <= '0; rdata <= '0;
      rs1 <= 1'b1; rs2 <= 1'b1;
      done <= 1'b0; done_err <= 1'b0;
    end else begin
      rs1 <= ata_ready;
      rs2 <= rs1;
      done <= 1'b0;
      done_err <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          wr_q <= req_write; ctl_q <= req_ctl;
          addr_q <= req_addr; wd_q <= req_wdata;
          cnt <= cfg_setup;
          st <= S_SETUP;
        end
        S_SETUP: if (min_done) begin
          cnt <= cfg_strobe; wcnt <= '0;
          st <= S_STROBE;
        end else cnt <= cnt - 1'b1;
        S_STROBE: if (!min_done) cnt <= cnt - 1'b1;
          else if (rs2 || tmo) begin
            err_q <= !rs2;
            if (!wr_q) rdata <= ata_dd;
            cnt <= cfg_hold;
            st <= S_HOLD;
          end else wcnt <= wcnt + 1'b1;
        S_HOLD: if (min_done) begin
          done <= 1'b1; done_err <= err_q;
          st <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_cs1_n && !ata_cs3_n));
  a_r2_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_cs1_n || !ata_cs3_n) && $past(!ata_cs1_n || !ata_cs3_n) |-> $stable(ata_da));
  a_r3_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_rd_n || !ata_wr_n) |-> (!ata_cs1_n || !ata_cs3_n));
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_rd_n && !ata_wr_n));
  a_r7_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_rd_n |-> !dd_oe);
  a_r8_drive_through_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ata_wr_n) |-> dd_oe);
  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ata_cs1_n && ata_cs3_n);

endmodule

// File: tb/sim_ata_pio_engine.sv
module sim_ata_pio_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_ctl = 0, ata_ready = 1;
  logic [2:0]  req_addr = 0;
  logic [15:0] req_wdata = 0, dev_data = 0;
  logic [7:0]  cfg_setup = 1, cfg_strobe = 1, cfg_hold = 1;
  logic [11:0] cfg_timeout = 0;
  logic        req_ack, done, done_err, cs1_n, cs3_n, rd_n, wr_n;
  logic [15:0] rdata;
  logic [2:0]  da;
  wire  [15:0] dd;

  assign dd = !rd_n ? dev_data : 16'bz;

  ata_pio_engine u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(req_ack),
    .req_write(req_write), .req_ctl(req_ctl), .req_addr(req_addr),
    .req_wdata(req_wdata), .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe),
    .cfg_hold(cfg_hold), .cfg_timeout(cfg_timeout), .done(done),
    .done_err(done_err), .rdata(rdata), .ata_cs1_n(cs1_n), .ata_cs3_n(cs3_n),
    .ata_da(da), .ata_dd(dd), .ata_rd_n(rd_n), .ata_wr_n(wr_n),
    .ata_ready(ata_ready));

  int errors = 0, checks = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // write, ctl, addr, data, setup, strobe, hold, k (0 = ready high), timeout
  localparam int NV = 9;
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd0, 16'hA55A, 8'd2, 8'd3, 8'd1, 8'd0,   12'd5},
    {1'b1, 1'b0, 3'd7, 16'h1234, 8'd1, 8'd1, 8'd2, 8'd0,   12'd5},
    {1'b0, 1'b1, 3'd6, 16'hC3C3, 8'd0, 8'd0, 8'd0, 8'd0,   12'd5},
    {1'b1, 1'b1, 3'd2, 16'hBEEF, 8'd3, 8'd2, 8'd3, 8'd4,   12'd10},
    {1'b0, 1'b0, 3'd5, 16'h0F0F, 8'd1, 8'd5, 8'd1, 8'd1,   12'd5},
    {1'b0, 1'b0, 3'd1, 16'h8001, 8'd2, 8'd2, 8'd1, 8'd200, 12'd3},
    {1'b1, 1'b0, 3'd3, 16'hFFFF, 8'd1, 8'd1, 8'd1, 8'd200, 12'd0},
    {1'b0, 1'b0, 3'd4, 16'h7E7E, 8'd1, 8'd3, 8'd1, 8'd1,   12'd0},
    {1'b1, 1'b1, 3'd1, 16'h0001, 8'd4, 8'd1, 8'd1, 8'd2,   12'd1}
  };

  task automatic run(input logic [64:0] v);
    logic w, c; logic [2:0] a; logic [15:0] d;
    int s, st, h, k, t, wp, exp_st, su, sc, ho, guard;
    bit exp_err, map_ok, da_ok, wd_ok;
    {w, c, a, d} = v[64:44];
    s = int'(v[43:36]); st = int'(v[35:28]); h = int'(v[27:20]);
    k = int'(v[19:12]); t = int'(v[11:0]);
    wp = (st < 1) ? 1 : st;
    exp_err = (k != 0) && (k + 2 > wp + t);
    exp_st = (k == 0) ? wp : (exp_err ? wp + t : ((wp > k + 2) ? wp : k + 2));
    @(negedge clk);
    cfg_setup = v[43:36]; cfg_strobe = v[35:28]; cfg_hold = v[27:20];
    cfg_timeout = v[11:0];
    dev_data = ~d;
    req_write = w; req_ctl = c; req_addr = a; req_wdata = d;
    if (k != 0) ata_ready = 0;
    req_valid = 1;
    #1 chk(req_ack === 1'b1, "R9 ack when idle", int'(req_ack), 1);
    @(negedge clk);
    req_valid = 0;
    su = 0; sc = 0; ho = 0; guard = 0;
    map_ok = 1; da_ok = 1; wd_ok = 1;
    while (!done && guard < 400) begin
      guard++;
      if (!cs1_n || !cs3_n) begin
        if ((c == 0 && !(cs3_n && !cs1_n)) || (c == 1 && !(cs1_n && !cs3_n))) map_ok = 0;
        if (da !== a) da_ok = 0;
      end
      if (!rd_n || !wr_n) begin
        sc++;
        if ((w && rd_n === 1'b0) || (!w && wr_n === 1'b0)) map_ok = 0;
        if (w && dd !== d) wd_ok = 0;
        if (sc == 1) begin
          dev_data = d;
          req_valid = 1;
          #1 chk(req_ack === 1'b0, "R9 no ack when busy", int'(req_ack), 0);
          req_valid = 0;
        end
        if (sc == k) ata_ready = 1;
      end else if (!cs1_n || !cs3_n) begin
        if (sc == 0) su++; else ho++;
      end
      @(negedge clk);
    end
    ata_ready = 1;
    chk(done === 1'b1, "R10 done seen", int'(done), 1);
    chk(cs1_n && cs3_n, "R10 selects released at done", int'({cs1_n, cs3_n}), 3);
    chk(map_ok, "R1 select/strobe mapping", int'(map_ok), 1);
    chk(da_ok, "R2 address", int'(da), int'(a));
    chk(su == ((s < 1) ? 1 : s), "R3 setup clocks", su, (s < 1) ? 1 : s);
    chk(ho == ((h < 1) ? 1 : h), "R3 hold clocks", ho, (h < 1) ? 1 : h);
    if (k == 0) chk(sc == exp_st, "R4 strobe width", sc, exp_st);
    else if (!exp_err) chk(sc == exp_st, "R5 stretched strobe", sc, exp_st);
    else chk(sc == exp_st, "R6 timeout strobe", sc, exp_st);
    chk(done_err === exp_err, "R6 error flag", int'(done_err), int'(exp_err));
    if (w) chk(wd_ok, "R8 write data in strobe", int'(wd_ok), 1);
    else chk(rdata === d, "R7 read capture at release", int'(rdata), int'(d));
    @(negedge clk);
    chk(done === 1'b0, "R10 single pulse", int'(done), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #5;
    chk(cs1_n && cs3_n && rd_n && wr_n, "R11 reset lines", int'({cs1_n, cs3_n, rd_n, wr_n}), 15);
    chk(!done && !done_err && !req_ack, "R11 reset status", int'({done, done_err, req_ack}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(cs1_n && cs3_n, "R1 idle selects high", int'({cs1_n, cs3_n}), 3);
    for (int i = 0; i < NV; i++) run(VEC[i]);
    run({1'b1, 1'b0, 3'd5, 16'h5AA5, 8'd1, 8'd2, 8'd1, 8'd0, 12'd2});
    run({1'b0, 1'b0, 3'd5, 16'h6006, 8'd1, 8'd2, 8'd1, 8'd0, 12'd2});
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule